// File: doc/BRIEF.md
# Burst Byte-Enable Rule Checker

This block watches the command side of a 64-bit memory-mapped slave port. It judges every accepted read command and every accepted write beat against the byte-enable rules that the downstream request splitters depend on. Write bursts are followed beat by beat. The burst length is taken from the burst count on the first beat of the burst, and the checker then knows whether each later beat is the opening, a middle or the closing beat. A read burst is judged in the single cycle in which its command is accepted.

When a rule is broken, the checker raises a one-cycle error pulse carrying a violation code. Only the first violation in a write burst is reported. When the request ends, a one-cycle abort mark tells the completion logic to answer that request with abort status. The checker only observes the port. It never changes or stalls traffic, and it never looks at data.

Top module: `burst_be_checker`

## Requirements
- R1: While reset is held and after it is released, with no traffic, `errValid` and `abortValid` are 0 and `errCode` is 0.
- R2: A write or read whose burst count is 0 or 1 is a single-beat request. It never raises an error or an abort, whatever its byte enables are.
- R3: On the first beat of a write burst longer than one beat, a byte enable of all zeros raises code 1. Outputs are registered and appear in the cycle after the beat is accepted.
- R4: A write burst longer than one beat raises code 2 (hole) if its first beat is nonzero but its set lanes do not form one run that reaches lane 7. It also raises code 2 if its last beat's set lanes do not form one run that starts at lane 0. An all-zero last beat is legal.
- R5: A middle beat of a write burst (neither first nor last) whose byte enable is not 8'hFF raises code 3.
- R6: An accepted read whose burst count is greater than 1 and whose byte enable is not 8'hFF raises code 4 in the next cycle.
- R7: At most one error is reported per write burst, at the beat where the first violation is found. Later violations in the same burst raise no error.
- R8: `abortValid` pulses for one cycle in the cycle after the final beat of a write burst that had any violation, or after a read command that raised code 4. It stays low after clean requests.
- R9: `errValid` is a single-cycle pulse per violation, `errCode` lies in 1..4 while it is high, and `errCode` is 0 whenever it is low.
- R10: The burst count is sampled only on the first beat of a write burst. Its value on later beats of that burst has no effect on how the beats are classified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rdValid | input | 1 | A read command is accepted this cycle |
| wrValid | input | 1 | A write beat is accepted this cycle |
| burstCount | input | BC_W (7) | Burst length in beats; 0 is treated as 1 |
| byteEn | input | BE_W (8) | Byte enables of the accepted beat, lane 0 in bit 0 |
| errValid | output | 1 | One-cycle violation pulse |
| errCode | output | 3 | 1 empty first, 2 hole, 3 partial middle, 4 partial read; 0 when idle |
| abortValid | output | 1 | One-cycle mark: complete the request just ended with abort status |

## Verification
The bench uses the default parameters: BE_W of 8 lanes and BC_W of 7 bits. With 7 bits, burst counts reach 64 beats, which is the 512-byte case, and a full 64-beat burst is run directly. The random bursts use lengths 0 to 8. This mixes single-beat, two-beat and long bursts, which places first, middle and last beats next to one another. Later beats carry random burst counts to show that only the first beat's count matters.

// File: rtl/beck_pkg.sv
package beck_pkg;

  typedef enum logic [2:0] {
    VC_NONE        = 3'd0,
    VC_EMPTY_FIRST = 3'd1,
    VC_HOLE        = 3'd2,
    VC_PARTIAL_MID = 3'd3,
    VC_PARTIAL_RD  = 3'd4
  } violCode_t;

  // Strobes from the position tracker to the lane datapath
  typedef struct packed {
    logic chkFirst;  // opening beat of a multi-beat write
    logic chkMid;    // middle beat of a multi-beat write
    logic chkLast;   // closing beat of a multi-beat write
    logic chkRead;   // multi-beat read command
    logic mute;      // burst already reported
  } chkStrobe_t;

endpackage

// File: rtl/burst_be_ctrl.sv
module burst_be_ctrl
  import beck_pkg::*;
#(
  parameter int BC_W = 7
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            rdValid,
  input  logic            wrValid,
  input  logic [BC_W-1:0] burstCount,
  input  logic            violNow,
  output chkStrobe_t      strb,
  output logic            abortValid
);

  localparam logic [BC_W-1:0] ONE = BC_W'(1);

  logic            active;
  logic [BC_W-1:0] beatsLeft;
  logic            flagged;
  logic [BC_W-1:0] lenNow;
  logic            multiNow;
  logic            lastBeat;

  always_comb begin
    lenNow   = (burstCount == '0) ? ONE : burstCount;
    multiNow = lenNow > ONE;
    lastBeat = wrValid & (active ? (beatsLeft == ONE) : !multiNow);
    strb.chkFirst = wrValid & !active & multiNow;
    strb.chkMid   = wrValid & active & (beatsLeft != ONE);
    strb.chkLast  = wrValid & active & (beatsLeft == ONE);
    strb.chkRead  = rdValid & (burstCount > ONE);
    strb.mute     = wrValid & active & flagged;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active     <= 1'b0;
      beatsLeft  <= '0;
      flagged    <= 1'b0;
      abortValid <= 1'b0;
    end else begin
      abortValid <= (rdValid & violNow) |
                    (lastBeat & ((active & flagged) | violNow));
      if (wrValid) begin
        if (lastBeat) begin
          active  <= 1'b0;
          flagged <= 1'b0;
        end else if (!active) begin
          active    <= 1'b1;
          beatsLeft <= lenNow - ONE;
          flagged   <= violNow;
        end else begin
          beatsLeft <= beatsLeft - ONE;
          flagged   <= flagged | violNow;
        end
      end
    end
  end

  AST_NO_RD_WR_SAME_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    !(rdValid && wrValid)); // R9
  AST_SINGLE_BEAT_FREE: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && !active && burstCount <= ONE) |-> !violNow); // R2
  AST_ONCE_PER_BURST: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && active && flagged) |-> !violNow); // R7
  AST_ABORT_AFTER_END: assert property (@(posedge clk) disable iff (!rstN)
    abortValid |-> !active); // R8

endmodule

// File: rtl/burst_be_dpath.sv
module burst_be_dpath
  import beck_pkg::*;
#(
  parameter int BE_W = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  chkStrobe_t      strb,
  input  logic [BE_W-1:0] byteEn,
  output logic            violNow,
  output logic [2:0]      errCode,
  output logic            errValid
);

  localparam logic [BE_W-1:0] FULL = '1;
  localparam logic [BE_W-1:0] LSB  = BE_W'(1);

  logic      lowRun;   // set lanes form one run starting at lane 0
  logic      highRun;  // set lanes form one run ending at top lane
  logic      isEmpty;
  violCode_t code;

  assign lowRun  = ((byteEn & (byteEn + LSB)) == '0);
  assign highRun = (((~byteEn) & ((~byteEn) + LSB)) == '0);
  assign isEmpty = (byteEn == '0);

  always_comb begin
    code = VC_NONE;
    if (strb.chkRead && byteEn != FULL)       code = VC_PARTIAL_RD;
    else if (strb.chkFirst && isEmpty)        code = VC_EMPTY_FIRST;
    else if (strb.chkFirst && !highRun)       code = VC_HOLE;
    else if (strb.chkMid && byteEn != FULL)   code = VC_PARTIAL_MID;
    else if (strb.chkLast && !lowRun)         code = VC_HOLE;
    violNow = (code != VC_NONE) && !strb.mute;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      errValid <= 1'b0;
      errCode  <= 3'd0;
    end else begin
      errValid <= violNow;
      errCode  <= violNow ? code : 3'd0;
    end
  end

  AST_CODE_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    errValid |-> (errCode >= 3'd1 && errCode <= 3'd4)); // R9
  AST_IDLE_CODE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !errValid |-> errCode == 3'd0); // R9
  AST_READ_ONLY_CODE4: assert property (@(posedge clk) disable iff (!rstN)
    strb.chkRead |=> (errCode == 3'd0 || errCode == 3'd4)); // R6
  AST_FULL_MID_CLEAN: assert property (@(posedge clk) disable iff (!rstN)
    (strb.chkMid && byteEn == FULL) |=> !errValid); // R5

endmodule

// File: rtl/burst_be_checker.sv
module burst_be_checker
  import beck_pkg::*;
#(
  parameter int BC_W = 7,
  parameter int BE_W = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            rdValid,
  input  logic            wrValid,
  input  logic [BC_W-1:0] burstCount,
  input  logic [BE_W-1:0] byteEn,
  output logic            errValid,
  output logic [2:0]      errCode,
  output logic            abortValid
);

  chkStrobe_t strb;
  logic       violNow;

  burst_be_ctrl #(.BC_W(BC_W)) uCtrl (
    .clk(clk), .rstN(rstN), .rdValid(rdValid), .wrValid(wrValid),
    .burstCount(burstCount), .violNow(violNow), .strb(strb),
    .abortValid(abortValid)
  );

  burst_be_dpath #(.BE_W(BE_W)) uDpath (
    .clk(clk), .rstN(rstN), .strb(strb), .byteEn(byteEn),
    .violNow(violNow), .errCode(errCode), .errValid(errValid)
  );

endmodule

// File: tb/sim_burst_be_checker.sv
`timescale 1ns/1ps
module sim_burst_be_checker;

  logic       clk = 1'b0;
  logic       rstN;
  logic       rdValid, wrValid;
  logic [6:0] burstCount;
  logic [7:0] byteEn;
  logic       errValid, abortValid;
  logic [2:0] errCode;

  int  nTests = 0;
  int  nFails = 0;
  bit  done   = 0;

  // bench model state for the write burst in flight
  bit  mAct  = 0;
  bit  mFlag = 0;
  int  mLen  = 0;
  int  mIdx  = 0;

  always #2.5 clk = ~clk;

  burst_be_checker u0 (
    .clk(clk), .rstN(rstN), .rdValid(rdValid), .wrValid(wrValid),
    .burstCount(burstCount), .byteEn(byteEn), .errValid(errValid),
    .errCode(errCode), .abortValid(abortValid)
  );

  // lanes scanned one by one: once a clear lane is seen, no set lane may follow
  function automatic bit runFromBottom(logic [7:0] x);
    bit seenClear = 0;
    for (int i = 0; i < 8; i++) begin
      if (!x[i]) seenClear = 1;
      else if (seenClear) return 0;
    end
    return 1;
  endfunction

  function automatic bit runToTop(logic [7:0] x);
    bit seenSet = 0;
    for (int i = 0; i < 8; i++) begin
      if (x[i]) seenSet = 1;
      else if (seenSet) return 0;
    end
    return 1;
  endfunction

  function automatic int wrExpCode(int len, int idx, logic [7:0] be);
    if (len <= 1) return 0;
    if (idx == 0) begin
      if (be == 8'h00) return 1;
      if (!runToTop(be)) return 2;
      return 0;
    end
    if (idx == len - 1) return runFromBottom(be) ? 0 : 2;
    return (be == 8'hFF) ? 0 : 3;
  endfunction

  function automatic int rdExpCode(int bc, logic [7:0] be);
    return (bc > 1 && be != 8'hFF) ? 4 : 0;
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    nTests++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic checkOut(string tag, bit eErr, int eCode, bit eAb);
    check(tag, "errValid", int'(errValid), int'(eErr));
    check(tag, "errCode", int'(errCode), eCode);
    check(tag, "abortValid", int'(abortValid), int'(eAb));
  endtask

  // called at a negedge; drives one write beat and checks one cycle later
  task automatic wrBeat(int bc, logic [7:0] be, string tag);
    int len, idx, c;
    bit eErr, eAb, last;
    if (!mAct) begin
      len = (bc == 0) ? 1 : bc; idx = 0; mFlag = 0;
    end else begin
      len = mLen; idx = mIdx;
    end
    c    = wrExpCode(len, idx, be);
    last = (idx == len - 1);
    eErr = (c != 0) && !mFlag;
    eAb  = last && (mFlag || c != 0);
    if (c != 0) mFlag = 1;
    if (last) mAct = 0;
    else begin mAct = 1; mLen = len; mIdx = idx + 1; end
    wrValid = 1'b1; burstCount = 7'(bc); byteEn = be;
    @(negedge clk);
    wrValid = 1'b0;
    checkOut(tag, eErr, eErr ? c : 0, eAb);
  endtask

  task automatic rdCmd(int bc, logic [7:0] be, string tag);
    int c;
    c = rdExpCode(bc, be);
    rdValid = 1'b1; burstCount = 7'(bc); byteEn = be;
    @(negedge clk);
    rdValid = 1'b0;
    checkOut(tag, c != 0, c, c != 0);
  endtask

  function automatic logic [7:0] pickBe(int len, int idx);
    if ($urandom % 4 == 0) return 8'($urandom);
    if (len <= 1) return 8'($urandom);
    if (idx == 0) return 8'hFF << ($urandom % 8);
    if (idx == len - 1) return 8'hFF >> ($urandom % 9);
    return 8'hFF;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nTests, nFails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rstN = 1'b0; rdValid = 1'b0; wrValid = 1'b0; burstCount = '0; byteEn = '0;
    repeat (3) @(negedge clk);
    checkOut("R1 in reset", 0, 0, 0);
    rstN = 1'b1;
    @(negedge clk);
    checkOut("R1 after reset", 0, 0, 0);

    // R2 single-beat requests carry no rule
    wrBeat(1, 8'h00, "R2 write bc1 empty");
    wrBeat(0, 8'h5A, "R2 write bc0 holes");
    rdCmd(1, 8'h00, "R2 read bc1 empty");
    rdCmd(0, 8'h81, "R2 read bc0 holes");

    // R3 empty opening beat, then R8 abort at end, R7 silence
    wrBeat(3, 8'h00, "R3 empty first");
    wrBeat(3, 8'hFF, "R7 muted mid");
    wrBeat(3, 8'hFF, "R8 abort at end");

    // R4 legal partial edges, then holes
    wrBeat(2, 8'hF0, "R4 legal top run");
    wrBeat(2, 8'h0F, "R4 legal bottom run");
    wrBeat(2, 8'hFF, "R4 full first");
    wrBeat(2, 8'h00, "R4 empty last legal");
    wrBeat(2, 8'h0F, "R4 first not to top");
    wrBeat(2, 8'hFF, "R8 end after hole");
    wrBeat(2, 8'hFF, "R4 full first");
    wrBeat(2, 8'hF0, "R4 last not from bottom");

    // R5 partial middle
    wrBeat(3, 8'hFF, "R5 first");
    wrBeat(3, 8'h7F, "R5 partial mid");
    wrBeat(3, 8'hFF, "R8 end after mid");

    // R7 several violations, one report
    wrBeat(4, 8'h00, "R7 first report");
    wrBeat(4, 8'h7F, "R7 muted mid a");
    wrBeat(4, 8'h0F, "R7 muted mid b");
    wrBeat(4, 8'h05, "R7 muted last");

    // R6 reads
    rdCmd(4, 8'hFE, "R6 partial read");
    rdCmd(4, 8'hFF, "R6 full read");
    rdCmd(64, 8'h00, "R6 empty read");

    // R10 later burst counts ignored
    wrBeat(3, 8'hFF, "R10 first");
    wrBeat(1, 8'h0F, "R10 mid bc1");
    wrBeat(0, 8'hFF, "R10 last bc0");

    // 64-beat clean burst
    for (int i = 0; i < 64; i++)
      wrBeat((i == 0) ? 64 : int'($urandom % 128),
             (i == 0) ? 8'hF8 : ((i == 63) ? 8'h07 : 8'hFF), "R10 long burst");

    // random mix
    for (int b = 0; b < 400; b++) begin
      int len;
      len = int'($urandom % 9);
      if ($urandom % 4 == 0) begin
        rdCmd(len, ($urandom % 2 == 0) ? 8'hFF : 8'($urandom), "R6 random read");
      end else begin
        for (int i = 0; i < ((len == 0) ? 1 : len); i++)
          wrBeat((i == 0) ? len : int'($urandom % 128), pickBe(len, i),
                 "R3/R4/R5/R7/R8 random write");
      end
      if ($urandom % 3 == 0) begin
        @(negedge clk);
        checkOut("R9 idle", 0, 0, 0);
      end
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end

endmodule